// File: doc/BRIEF.md
# J-K Symbol-Pair Framer

This block sits on the receive side of a serial ring link. It takes 5-bit code symbols, one per cycle of the recovered clock whenever the symbol strobe is high. It watches for a J symbol followed directly by a K symbol, which is the starting delimiter of a frame. The position of that pair fixes where each two-symbol unit begins. From then on the framer packs every two accepted symbols into one 10-bit pair. The first symbol goes in the upper half. Each pair comes with a one-cycle valid strobe. The stage that follows the framer is an elasticity buffer.

A starting delimiter may arrive at the phase opposite to the current alignment. The framer then moves its boundary so that the J opens a pair. It emits the J-K pair as a start-of-frame unit and pulses a realign flag. The J in that case has already left as the lower half of the previous pair. An in-frame flag rises with each start-of-frame pair. It falls with the first pair that carries an ending-delimiter symbol.

Top module: `jk_framer`

## Requirements
- R1: After reset, pair valid, start flag, realign flag and in-frame flag are all low.
- R2: Until the first J (11000) directly followed by K (10001) has been accepted, pair valid stays low, whatever the symbols.
- R3: When K is accepted right after an accepted J, the cycle after that K shows pair = {J, K} with J in bits 9:5, pair valid high and the start flag high.
- R4: Once aligned, every second accepted symbol completes a pair. The earlier symbol is in bits 9:5 and the later one in bits 4:0. Pair valid is high for the one cycle after the completing symbol.
- R5: Cycles with the symbol strobe low are not symbols: they neither advance the pairing nor break a J-K adjacency, and pair valid is low in the following cycle.
- R6: A J that is not followed by K leaves the alignment unchanged, in either half of a pair.
- R7: A J-K pair whose J was the second half of a pair realigns the boundary. {J, K} is emitted with the start flag and a one-cycle realign pulse, even when it directly follows the previous pair, and later pairs begin after the K.
- R8: A J-K pair already on the current boundary raises the start flag without a realign pulse.
- R9: The in-frame flag goes high together with a start-of-frame pair. It goes low together with the first later pair that holds the ending symbol T (01101) in either half.
- R10: The start flag is never high without pair valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_i | input | 5 | Incoming code symbol |
| sym_vld_i | input | 1 | Symbol strobe, high when sym_i carries a symbol |
| pair_o | output | 10 | Aligned symbol pair, first symbol in the upper half |
| pair_vld_o | output | 1 | One-cycle strobe for pair_o |
| sd_o | output | 1 | pair_o is a starting delimiter |
| realign_o | output | 1 | Boundary moved with this starting delimiter |
| in_frame_o | output | 1 | Between a starting delimiter and an ending symbol |

## Verification
Two events can land in the same cycle. One is the completion of an ordinary pair whose lower half is a J. The other is the realignment caused by a K accepted directly after that J. The bench provokes this by sending a data symbol, then J, then K on consecutive cycles while aligned. It expects two pair strobes back to back: {data, J} first, then {J, K} with start and realign both high and the in-frame flag held. It then checks that the next two symbols pair up on the new boundary.

// File: rtl/jkf_pkg.sv
package jkf_pkg;
    localparam int unsigned DEF_SYM_W = 5;
    localparam logic [DEF_SYM_W-1:0] DEF_J = 5'b11000;
    localparam logic [DEF_SYM_W-1:0] DEF_K = 5'b10001;
    localparam logic [DEF_SYM_W-1:0] DEF_T = 5'b01101;

    // PH_OPEN: no symbol pending, next accepted symbol starts a pair
    // PH_HALF: one symbol pending, next accepted symbol closes a pair
    typedef enum logic {PH_OPEN = 1'b0, PH_HALF = 1'b1} phase_e;
endpackage

// File: rtl/jkf_sym_match.sv
module jkf_sym_match #(
    parameter int unsigned SYM_W = 5,
    parameter logic [SYM_W-1:0] CODE = '0
) (
    input  logic [SYM_W-1:0] sym_i,
    output logic             hit_o
);
    always_comb begin
        hit_o = (sym_i == CODE);
    end
endmodule

// File: rtl/jkf_align_core.sv
module jkf_align_core
    import jkf_pkg::*;
#(
    parameter int unsigned SYM_W = 5,
    localparam int unsigned PAIR_W = 2 * SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYM_W-1:0]  sym_i,
    input  logic              sym_vld_i,
    input  logic              sym_is_k_i,
    input  logic              held_is_j_i,
    output logic [SYM_W-1:0]  held_sym_o,
    output logic [PAIR_W-1:0] nxt_pair_o,
    output logic              nxt_vld_o,
    output logic              nxt_sd_o,
    output logic [PAIR_W-1:0] pair_o,
    output logic              pair_vld_o,
    output logic              sd_o,
    output logic              realign_o
);
    typedef struct packed {
        logic [SYM_W-1:0]  held;
        logic              held_ok;
        logic              locked;
        phase_e            phase;
        logic [PAIR_W-1:0] pair;
        logic              pair_vld;
        logic              sd;
        logic              realign;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     jk_seen;

    always_comb begin
        st_d          = st_q;
        st_d.pair_vld = 1'b0;
        st_d.sd       = 1'b0;
        st_d.realign  = 1'b0;
        jk_seen       = st_q.held_ok && held_is_j_i && sym_is_k_i;
        if (sym_vld_i) begin
            st_d.held    = sym_i;
            st_d.held_ok = 1'b1;
            if (jk_seen) begin
                st_d.pair     = {st_q.held, sym_i};
                st_d.pair_vld = 1'b1;
                st_d.sd       = 1'b1;
                st_d.realign  = st_q.locked && (st_q.phase == PH_OPEN);
                st_d.locked   = 1'b1;
                st_d.phase    = PH_OPEN;
            end else if (st_q.locked) begin
                if (st_q.phase == PH_HALF) begin
                    st_d.pair     = {st_q.held, sym_i};
                    st_d.pair_vld = 1'b1;
                    st_d.phase    = PH_OPEN;
                end else begin
                    st_d.phase = PH_HALF;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{held: '0, held_ok: 1'b0, locked: 1'b0, phase: PH_OPEN,
                      pair: '0, pair_vld: 1'b0, sd: 1'b0, realign: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign held_sym_o = st_q.held;
    assign nxt_pair_o = st_d.pair;
    assign nxt_vld_o  = st_d.pair_vld;
    assign nxt_sd_o   = st_d.sd;
    assign pair_o     = st_q.pair;
    assign pair_vld_o = st_q.pair_vld;
    assign sd_o       = st_q.sd;
    assign realign_o  = st_q.realign;

    // R5: an empty symbol slot never produces a pair in the next cycle
    p_idle_no_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld_i |=> !pair_vld_o);

    // R2: no pair leaves the core while alignment has not been found
    p_silent_unlocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.locked |=> !pair_vld_o || sd_o);
endmodule

// File: rtl/jkf_frame_track.sv
module jkf_frame_track #(
    parameter int unsigned SYM_W = 5,
    parameter logic [SYM_W-1:0] T_CODE = 5'b01101,
    localparam int unsigned PAIR_W = 2 * SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] nxt_pair_i,
    input  logic              nxt_vld_i,
    input  logic              nxt_sd_i,
    output logic              in_frame_o
);
    typedef struct packed {
        logic in_frame;
    } trk_st_t;

    trk_st_t    st_d, st_q;
    logic [1:0] half_is_t;

    for (genvar h = 0; h < 2; h++) begin : g_half
        jkf_sym_match #(.SYM_W(SYM_W), .CODE(T_CODE)) u_t_match (
            .sym_i (nxt_pair_i[h*SYM_W +: SYM_W]),
            .hit_o (half_is_t[h])
        );
    end

    always_comb begin
        st_d = st_q;
        if (nxt_vld_i) begin
            if (nxt_sd_i) begin
                st_d.in_frame = 1'b1;
            end else if (|half_is_t) begin
                st_d.in_frame = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{in_frame: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_frame_o = st_q.in_frame;

    // R9: the flag only drops on a cycle that carries a pair
    p_frame_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.in_frame && nxt_vld_i && !nxt_sd_i && (|half_is_t) |=> !in_frame_o);
endmodule

// File: rtl/jk_framer.sv
module jk_framer
    import jkf_pkg::*;
#(
    parameter int unsigned SYM_W = DEF_SYM_W,
    parameter logic [SYM_W-1:0] J_CODE = DEF_J,
    parameter logic [SYM_W-1:0] K_CODE = DEF_K,
    parameter logic [SYM_W-1:0] T_CODE = DEF_T,
    localparam int unsigned PAIR_W = 2 * SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYM_W-1:0]  sym_i,
    input  logic              sym_vld_i,
    output logic [PAIR_W-1:0] pair_o,
    output logic              pair_vld_o,
    output logic              sd_o,
    output logic              realign_o,
    output logic              in_frame_o
);
    logic [SYM_W-1:0]  held_sym;
    logic [1:0]        slot_hit;
    logic [PAIR_W-1:0] nxt_pair;
    logic              nxt_vld;
    logic              nxt_sd;

    // slot 0 looks for K on the incoming symbol, slot 1 for J on the held one
    for (genvar g = 0; g < 2; g++) begin : g_slot
        localparam logic [SYM_W-1:0] SLOT_CODE = (g == 0) ? K_CODE : J_CODE;
        jkf_sym_match #(.SYM_W(SYM_W), .CODE(SLOT_CODE)) u_match (
            .sym_i (g == 0 ? sym_i : held_sym),
            .hit_o (slot_hit[g])
        );
    end

    jkf_align_core #(.SYM_W(SYM_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_i       (sym_i),
        .sym_vld_i   (sym_vld_i),
        .sym_is_k_i  (slot_hit[0]),
        .held_is_j_i (slot_hit[1]),
        .held_sym_o  (held_sym),
        .nxt_pair_o  (nxt_pair),
        .nxt_vld_o   (nxt_vld),
        .nxt_sd_o    (nxt_sd),
        .pair_o      (pair_o),
        .pair_vld_o  (pair_vld_o),
        .sd_o        (sd_o),
        .realign_o   (realign_o)
    );

    jkf_frame_track #(.SYM_W(SYM_W), .T_CODE(T_CODE)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_pair_i (nxt_pair),
        .nxt_vld_i  (nxt_vld),
        .nxt_sd_i   (nxt_sd),
        .in_frame_o (in_frame_o)
    );

    // R10: a start flag always travels with a valid pair
    p_sd_has_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sd_o |-> pair_vld_o);

    // R3: a start-of-frame unit carries J above K
    p_sd_content_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sd_o |-> pair_o == {J_CODE, K_CODE});

    // R7: a realign pulse is always part of a start-of-frame unit
    p_realign_is_sd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        realign_o |-> sd_o);

    // R7: back-to-back pair strobes only happen on a boundary move
    p_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld_o && $past(pair_vld_o) |-> realign_o);

    // R9: the in-frame flag rises only with a start-of-frame unit
    p_frame_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame_o) |-> sd_o);
endmodule

// File: tb/tb_jk_framer.sv
module tb_jk_framer;
    localparam logic [4:0] SJ = 5'b11000;
    localparam logic [4:0] SK = 5'b10001;
    localparam logic [4:0] ST = 5'b01101;
    localparam logic [4:0] DA = 5'b11110;
    localparam logic [4:0] DB = 5'b01001;
    localparam logic [4:0] DC = 5'b10100;
    localparam logic [4:0] DD = 5'b10101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] sym = '0;
    logic       vld = 1'b0;
    logic [9:0] pair;
    logic       pair_vld, sd, realign, in_frame;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    logic [9:0] c_pair;
    logic       c_vld, c_sd, c_rl, c_if;

    always #5 clk = ~clk;

    jk_framer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_i      (sym),
        .sym_vld_i  (vld),
        .pair_o     (pair),
        .pair_vld_o (pair_vld),
        .sd_o       (sd),
        .realign_o  (realign),
        .in_frame_o (in_frame)
    );

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] s, input logic v);
        @(negedge clk);
        sym = s;
        vld = v;
        @(posedge clk);
        #2;
        c_pair = pair;
        c_vld  = pair_vld;
        c_sd   = sd;
        c_rl   = realign;
        c_if   = in_frame;
    endtask

    task automatic expect_pair(input string req, input logic [4:0] a, input logic [4:0] b,
                               input logic e_sd, input logic e_rl);
        chk({req, " vld"}, {9'd0, c_vld}, 10'd1);
        chk({req, " pair"}, c_pair, {a, b});
        chk({req, " sd"}, {9'd0, c_sd}, {9'd0, e_sd});
        chk({req, " realign"}, {9'd0, c_rl}, {9'd0, e_rl});
    endtask

    task automatic expect_none(input string req);
        chk({req, " no pair"}, {9'd0, c_vld}, 10'd0);
        chk({req, " no sd"}, {9'd0, c_sd}, 10'd0);
    endtask

    task automatic t_reset;
        #2;
        chk("R1 vld", {9'd0, pair_vld}, 10'd0);
        chk("R1 sd", {9'd0, sd}, 10'd0);
        chk("R1 realign", {9'd0, realign}, 10'd0);
        chk("R1 in_frame", {9'd0, in_frame}, 10'd0);
    endtask

    task automatic t_prelock;
        step(DA, 1'b1); expect_none("R2");
        step(SK, 1'b1); expect_none("R2");
        step(SJ, 1'b1); expect_none("R2");
        step(DB, 1'b1); expect_none("R2");
        step(DC, 1'b1); expect_none("R2");
        step(SJ, 1'b1); expect_none("R2");
        step(SJ, 1'b1); expect_none("R2");
        step(DD, 1'b1); expect_none("R2");
    endtask

    task automatic t_first_lock;
        step(SJ, 1'b1); expect_none("R3 J alone");
        step(SK, 1'b1); expect_pair("R3", SJ, SK, 1'b1, 1'b0);
        chk("R9 rise", {9'd0, c_if}, 10'd1);
        chk("R10 sd with vld", {9'd0, c_sd & ~c_vld}, 10'd0);
    endtask

    task automatic t_stream;
        step(DA, 1'b1); expect_none("R4 half");
        step(DB, 1'b1); expect_pair("R4", DA, DB, 1'b0, 1'b0);
        step(DC, 1'b1); expect_none("R4 half");
        step(DD, 1'b1); expect_pair("R4", DC, DD, 1'b0, 1'b0);
        chk("R9 hold", {9'd0, c_if}, 10'd1);
    endtask

    task automatic t_gaps;
        step(DB, 1'b1); expect_none("R5 half");
        step(DD, 1'b0); expect_none("R5 gap");
        step(DD, 1'b0); expect_none("R5 gap");
        step(DC, 1'b1); expect_pair("R5", DB, DC, 1'b0, 1'b0);
        // J, gap, K still counts as adjacent in the symbol stream
        step(SJ, 1'b1); expect_none("R5 half");
        step(DA, 1'b0); expect_none("R5 gap");
        step(SK, 1'b1); expect_pair("R5 J-gap-K", SJ, SK, 1'b1, 1'b0);
    endtask

    task automatic t_lone_j;
        step(SJ, 1'b1); expect_none("R6 half");
        step(DA, 1'b1); expect_pair("R6 J first", SJ, DA, 1'b0, 1'b0);
        step(DB, 1'b1); expect_none("R6 half");
        step(SJ, 1'b1); expect_pair("R6 J second", DB, SJ, 1'b0, 1'b0);
        step(DC, 1'b1); expect_none("R6 kept");
        step(DD, 1'b1); expect_pair("R6 kept", DC, DD, 1'b0, 1'b0);
    endtask

    task automatic t_aligned_sd;
        step(SJ, 1'b1); expect_none("R8 half");
        step(SK, 1'b1); expect_pair("R8", SJ, SK, 1'b1, 1'b0);
    endtask

    // pair completion and boundary move in consecutive cycles
    task automatic t_realign;
        step(DA, 1'b1); expect_none("R7 half");
        step(SJ, 1'b1); expect_pair("R7 prior", DA, SJ, 1'b0, 1'b0);
        step(SK, 1'b1); expect_pair("R7", SJ, SK, 1'b1, 1'b1);
        chk("R7 in_frame", {9'd0, c_if}, 10'd1);
        step(DB, 1'b1); expect_none("R7 new half");
        chk("R7 pulse width", {9'd0, c_rl}, 10'd0);
        step(DC, 1'b1); expect_pair("R7 new boundary", DB, DC, 1'b0, 1'b0);
    endtask

    task automatic t_end_frame;
        step(ST, 1'b1); expect_none("R9 half");
        chk("R9 still in", {9'd0, c_if}, 10'd1);
        step(DA, 1'b1); expect_pair("R9 T upper", ST, DA, 1'b0, 1'b0);
        chk("R9 fall", {9'd0, c_if}, 10'd0);
        step(DB, 1'b1);
        step(DC, 1'b1); expect_pair("R9 out", DB, DC, 1'b0, 1'b0);
        chk("R9 stays low", {9'd0, c_if}, 10'd0);
        step(SJ, 1'b1);
        step(SK, 1'b1); expect_pair("R9 reenter", SJ, SK, 1'b1, 1'b0);
        chk("R9 rise again", {9'd0, c_if}, 10'd1);
        step(DD, 1'b1);
        step(ST, 1'b1); expect_pair("R9 T lower", DD, ST, 1'b0, 1'b0);
        chk("R9 fall lower", {9'd0, c_if}, 10'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        #20;
        @(negedge clk);
        rst_n = 1'b1;
        t_prelock();
        t_first_lock();
        t_stream();
        t_gaps();
        t_lone_j();
        t_aligned_sd();
        t_realign();
        t_end_frame();
        step(DA, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule